// File: doc/BRIEF.md
# Operand Address Generator for a Signal-Processing Core

This block forms the memory operand address for each data or program access of a signal-processing core. It holds eight register sets. Each set has a pointer, a step register and an arithmetic-control register. A request names one set and one of eight update codes. The block returns the effective address in the same cycle. On the next clock edge it writes the updated pointer back. Pointer arithmetic stays out of the data path, so a loop that walks a buffer spends no extra instructions on pointer maintenance.

Each set's arithmetic-control register chooses how that set's pointer moves:
- All ones gives plain two's-complement stepping.
- Zero gives bit-reversed stepping, used for FFT data reordering.
- Any other value M wraps the pointer inside a circular buffer of M+1 words.

A separate write port loads any register, and a read port returns any register. Together they let software set up a buffer and inspect pointers.

Top module: `dsp_agu`

## Requirements
- R1: After reset every pointer and every step register reads 0, and every arithmetic-control register reads 0xFFFF. Register select codes on the write and read ports are 0 = pointer, 1 = step, 2 = arithmetic control.
- R2: For update codes 000, 001, 010, 011, 100 and 110, `eaOut` equals the current pointer of the selected set, combinationally in the request cycle.
- R3: Code 101 (indexed) drives `eaOut` to pointer plus step, using the set's arithmetic, and leaves the pointer unchanged.
- R4: Code 011 adds one to the pointer and code 010 subtracts one, on the clock edge that ends the request cycle.
- R5: Code 001 adds the set's step register to the pointer and code 000 subtracts it.
- R6: Codes 100 and 110 leave the pointer unchanged.
- R7: Code 111 (pre-decrement) drives `eaOut` to pointer minus one and stores that same value as the new pointer.
- R8: With arithmetic control 0xFFFF, updates wrap modulo 2^16 (0x0000 minus one gives 0xFFFF, and 0xFFFF plus one gives 0x0000).
- R9: With arithmetic control M other than 0 and 0xFFFF, the buffer base is the pointer with its low bits cleared up to the smallest power of two at or above M+1. The pointer's offset from that base wraps inside 0..M, for step magnitudes up to M+1. This applies to the update codes and to the indexed address.
- R10: With arithmetic control 0, the step is added or subtracted with the carry running from bit 15 toward bit 0. For example, starting from 0 with step 0x8000, repeated increments give 0x8000, 0x4000, 0xC000.
- R11: A request on set k uses only step k and control k, and changes no register of any other set.
- R12: A write to the pointer of the set being updated in the same cycle wins over the update. A write to another register of that set does not block the update.
- R13: With `reqValid` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Update strike for the current request |
| reqSet | input | 3 | Register set used by the request |
| reqMode | input | 3 | Update code |
| eaOut | output | 16 | Effective address of the request |
| wrEn | input | 1 | Register write enable |
| wrSel | input | 2 | Register written: 0 pointer, 1 step, 2 control |
| wrSet | input | 3 | Set written |
| wrData | input | 16 | Write value |
| rdSel | input | 2 | Register read: 0 pointer, 1 step, 2 control |
| rdSet | input | 3 | Set read |
| rdData | output | 16 | Read value, combinational |

## Verification
A corrupted pointer shows on `eaOut` in the very next request to that set. It also shows on `rdData` one cycle after the bad write-back. A wrong step or control register stays hidden until an update or indexed access uses it. It then shows as a wrong address or a wrong stored pointer one edge later. The circular-buffer and bit-reversed sequences are therefore walked several steps, across both buffer ends. This catches errors that appear only at a wrap.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    MODE_DEC_STEP = 3'b000,
    MODE_INC_STEP = 3'b001,
    MODE_DEC_ONE  = 3'b010,
    MODE_INC_ONE  = 3'b011,
    MODE_HOLD     = 3'b100,
    MODE_INDEX    = 3'b101,
    MODE_SPARE    = 3'b110,
    MODE_PREDEC   = 3'b111
  } aguMode_e;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_STEP = 2'd1,
    SEL_CTRL = 2'd2
  } regSel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic byStep;     // use the step register instead of one
    logic goDown;     // subtract rather than add
    logic commit;     // write the stepped pointer back
    logic eaStepped;  // present the stepped value as the address
  } aguStrobe_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic       reqValid,
  input  logic [2:0] reqMode,
  output aguStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    unique case (aguMode_e'(reqMode))
      MODE_DEC_STEP: begin strobe.byStep = 1'b1; strobe.goDown = 1'b1; strobe.commit = reqValid; end
      MODE_INC_STEP: begin strobe.byStep = 1'b1; strobe.commit = reqValid; end
      MODE_DEC_ONE:  begin strobe.goDown = 1'b1; strobe.commit = reqValid; end
      MODE_INC_ONE:  begin strobe.commit = reqValid; end
      MODE_INDEX:    begin strobe.byStep = 1'b1; strobe.eaStepped = 1'b1; end
      MODE_PREDEC:   begin strobe.goDown = 1'b1; strobe.eaStepped = 1'b1; strobe.commit = reqValid; end
      default:       strobe = '0;  // hold and spare code
    endcase
  end

endmodule

// File: rtl/agu_arith.sv
module agu_arith #(
  parameter int W = 16
) (
  input  logic [W-1:0] curPtr,
  input  logic [W-1:0] curStep,
  input  logic [W-1:0] curCtrl,
  input  logic         byStep,
  input  logic         goDown,
  output logic [W-1:0] nextPtr
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] stepVal;
  logic [W-1:0] linNext;
  logic [W-1:0] revPtr, revStep, revSum, revNext;
  logic [W-1:0] bufMask, bufBase, bufOfs, modNext;
  logic [W:0]   bufSize, rawOfs, wrapOfs;
  logic         isLinear, isReverse;

  assign stepVal   = byStep ? curStep : ONE;
  assign isLinear  = (curCtrl == '1);
  assign isReverse = (curCtrl == '0);

  // Plain two's-complement step
  assign linNext = goDown ? (curPtr - stepVal) : (curPtr + stepVal);

  // Bit-reversed step: mirror operands, add, mirror back
  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign revPtr[i]  = curPtr[W-1-i];
    assign revStep[i] = stepVal[W-1-i];
    assign revNext[i] = revSum[W-1-i];
  end
  assign revSum = goDown ? (revPtr - revStep) : (revPtr + revStep);

  // Circular buffer step
  always_comb begin
    bufMask = curCtrl;
    for (int s = 1; s < W; s = s * 2) begin
      bufMask = bufMask | (bufMask >> s);
    end
  end

  assign bufBase = curPtr & ~bufMask;
  assign bufOfs  = curPtr & bufMask;
  assign bufSize = {1'b0, curCtrl} + {{W{1'b0}}, 1'b1};
  assign rawOfs  = goDown ? ({1'b0, bufOfs} - {1'b0, stepVal})
                          : ({1'b0, bufOfs} + {1'b0, stepVal});

  always_comb begin
    if (goDown) begin
      wrapOfs = rawOfs[W] ? (rawOfs + bufSize) : rawOfs;
    end else begin
      wrapOfs = (rawOfs > {1'b0, curCtrl}) ? (rawOfs - bufSize) : rawOfs;
    end
  end
  assign modNext = bufBase + wrapOfs[W-1:0];

  always_comb begin
    if (isLinear)       nextPtr = linNext;
    else if (isReverse) nextPtr = revNext;
    else                nextPtr = modNext;
  end

endmodule

// File: rtl/agu_regs.sv
module agu_regs
  import agu_pkg::*;
#(
  parameter int W     = 16,
  parameter int SETS  = 8,
  parameter int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [SET_W-1:0] wrSet,
  input  logic [W-1:0]     wrData,
  input  logic             updEn,
  input  logic [SET_W-1:0] updSet,
  input  logic [W-1:0]     updData,
  input  logic [SET_W-1:0] reqSet,
  output logic [W-1:0]     selPtr,
  output logic [W-1:0]     selStep,
  output logic [W-1:0]     selCtrl,
  input  logic [1:0]       rdSel,
  input  logic [SET_W-1:0] rdSet,
  output logic [W-1:0]     rdData
);

  logic [W-1:0] ptrQ  [SETS];
  logic [W-1:0] stepQ [SETS];
  logic [W-1:0] ctrlQ [SETS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < SETS; k++) begin
        ptrQ[k]  <= '0;
        stepQ[k] <= '0;
        ctrlQ[k] <= '1;
      end
    end else begin
      for (int k = 0; k < SETS; k++) begin
        if (wrEn && wrSet == SET_W'(k) && wrSel == SEL_PTR) begin
          ptrQ[k] <= wrData;
        end else if (updEn && updSet == SET_W'(k)) begin
          ptrQ[k] <= updData;
        end
        if (wrEn && wrSet == SET_W'(k) && wrSel == SEL_STEP) begin
          stepQ[k] <= wrData;
        end
        if (wrEn && wrSet == SET_W'(k) && wrSel == SEL_CTRL) begin
          ctrlQ[k] <= wrData;
        end
      end
    end
  end

  assign selPtr  = ptrQ[reqSet];
  assign selStep = stepQ[reqSet];
  assign selCtrl = ctrlQ[reqSet];

  always_comb begin
    case (rdSel)
      SEL_PTR:  rdData = ptrQ[rdSet];
      SEL_STEP: rdData = stepQ[rdSet];
      SEL_CTRL: rdData = ctrlQ[rdSet];
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
  import agu_pkg::*;
#(
  parameter int W     = 16,
  parameter int SETS  = 8,
  parameter int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [SET_W-1:0] reqSet,
  input  logic [2:0]       reqMode,
  output logic [W-1:0]     eaOut,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [SET_W-1:0] wrSet,
  input  logic [W-1:0]     wrData,
  input  logic [1:0]       rdSel,
  input  logic [SET_W-1:0] rdSet,
  output logic [W-1:0]     rdData
);

  aguStrobe_t strobe;
  logic [W-1:0] selPtr, selStep, selCtrl, nextPtr;

  agu_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqMode  (reqMode),
    .strobe   (strobe)
  );

  agu_regs #(.W(W), .SETS(SETS), .SET_W(SET_W)) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrSet   (wrSet),
    .wrData  (wrData),
    .updEn   (strobe.commit),
    .updSet  (reqSet),
    .updData (nextPtr),
    .reqSet  (reqSet),
    .selPtr  (selPtr),
    .selStep (selStep),
    .selCtrl (selCtrl),
    .rdSel   (rdSel),
    .rdSet   (rdSet),
    .rdData  (rdData)
  );

  agu_arith #(.W(W)) u_arith (
    .curPtr  (selPtr),
    .curStep (selStep),
    .curCtrl (selCtrl),
    .byStep  (strobe.byStep),
    .goDown  (strobe.goDown),
    .nextPtr (nextPtr)
  );

  assign eaOut = strobe.eaStepped ? nextPtr : selPtr;

endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int W     = 16,
  parameter int SET_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [SET_W-1:0] reqSet,
  input logic [2:0]       reqMode,
  input logic [W-1:0]     eaOut,
  input logic [W-1:0]     selPtr,
  input logic [W-1:0]     selStep,
  input logic [W-1:0]     selCtrl,
  input logic             wrEn,
  input logic [1:0]       wrSel,
  input logic [SET_W-1:0] wrSet,
  input logic [W-1:0]     wrData,
  input logic [1:0]       rdSel,
  input logic [SET_W-1:0] rdSet,
  input logic [W-1:0]     rdData
);

  a_r2_ea_is_pointer: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode != 3'b101 && reqMode != 3'b111) |-> eaOut == selPtr);

  a_r3_index_linear: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == 3'b101 && selCtrl == '1) |-> eaOut == selPtr + selStep);

  a_r7_predec_linear: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == 3'b111 && selCtrl == '1) |-> eaOut == selPtr - W'(1));

  a_r6_hold_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqMode == 3'b100 || reqMode == 3'b110 || reqMode == 3'b101)
     && !(wrEn && wrSel == 2'd0 && wrSet == reqSet))
    |=> (!(rdSel == 2'd0 && rdSet == $past(reqSet)) || rdData == $past(selPtr)));

  a_r12_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd0)
    |=> (!(rdSel == 2'd0 && rdSet == $past(wrSet)) || rdData == $past(wrData)));

  a_r13_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && !wrEn)
    |=> (!($stable(rdSel) && $stable(rdSet)) || $stable(rdData)));

endmodule

bind dsp_agu agu_checker #(.W(W), .SET_W(SET_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqSet   (reqSet),
  .reqMode  (reqMode),
  .eaOut    (eaOut),
  .selPtr   (selPtr),
  .selStep  (selStep),
  .selCtrl  (selCtrl),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .wrSet    (wrSet),
  .wrData   (wrData),
  .rdSel    (rdSel),
  .rdSet    (rdSet),
  .rdData   (rdData)
);

// File: tb/dsp_agu_bench.sv
module dsp_agu_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqSet = '0;
  logic [2:0]  reqMode = 3'b100;
  logic [15:0] eaOut;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [2:0]  wrSet = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdSel = '0;
  logic [2:0]  rdSet = '0;
  logic [15:0] rdData;

  always #5 clk = ~clk;

  dsp_agu u_dsp_agu (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSet(reqSet), .reqMode(reqMode),
    .eaOut(eaOut), .wrEn(wrEn), .wrSel(wrSel), .wrSet(wrSet), .wrData(wrData),
    .rdSel(rdSel), .rdSet(rdSet), .rdData(rdData)
  );

  typedef struct {
    bit          onRead;
    logic [15:0] expVal;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0;
  int  failures = 0;
  bit  probe = 1'b0;
  bit  finished = 1'b0;

  // Monitor: compares the expected item against the outputs mid-cycle
  always @(negedge clk) begin
    if (probe) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty: actual ea=%h rd=%h expected an item", eaOut, rdData);
      end else begin
        expItem_t it;
        logic [15:0] act;
        it  = expQ.pop_front();
        act = it.onRead ? rdData : eaOut;
        if (act !== it.expVal) begin
          failures++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.expVal);
        end
      end
    end
  end

  task automatic quiet();
    reqValid = 1'b0; reqMode = 3'b100; wrEn = 1'b0; probe = 1'b0;
  endtask

  task automatic doWrite(input logic [1:0] sel, input logic [2:0] set, input logic [15:0] data);
    @(posedge clk); #1;
    quiet();
    wrEn = 1'b1; wrSel = sel; wrSet = set; wrData = data;
  endtask

  task automatic doRead(input logic [1:0] sel, input logic [2:0] set, input logic [15:0] exp, input string tag);
    expItem_t it;
    @(posedge clk); #1;
    quiet();
    rdSel = sel; rdSet = set;
    it.onRead = 1'b1; it.expVal = exp; it.tag = tag;
    expQ.push_back(it);
    probe = 1'b1;
  endtask

  task automatic doAccess(input logic [2:0] set, input logic [2:0] mode, input logic [15:0] expEa, input string tag);
    expItem_t it;
    @(posedge clk); #1;
    quiet();
    reqValid = 1'b1; reqSet = set; reqMode = mode;
    it.onRead = 1'b0; it.expVal = expEa; it.tag = tag;
    expQ.push_back(it);
    probe = 1'b1;
  endtask

  task automatic doAccessWrite(input logic [2:0] set, input logic [2:0] mode, input logic [15:0] expEa,
                               input logic [1:0] sel, input logic [2:0] wset, input logic [15:0] data,
                               input string tag);
    expItem_t it;
    @(posedge clk); #1;
    quiet();
    reqValid = 1'b1; reqSet = set; reqMode = mode;
    wrEn = 1'b1; wrSel = sel; wrSet = wset; wrData = data;
    it.onRead = 1'b0; it.expVal = expEa; it.tag = tag;
    expQ.push_back(it);
    probe = 1'b1;
  endtask

  task automatic doIdle(input logic [2:0] set, input logic [2:0] mode);
    @(posedge clk); #1;
    quiet();
    reqSet = set; reqMode = mode;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    doRead(2'd0, 3'd0, 16'h0000, "R1 pointer 0");
    doRead(2'd1, 3'd5, 16'h0000, "R1 step 5");
    doRead(2'd2, 3'd7, 16'hFFFF, "R1 control 7");

    // Linear set 1: pointer 0x10, step 4
    doWrite(2'd0, 3'd1, 16'h0010);
    doWrite(2'd1, 3'd1, 16'h0004);
    doAccess(1, 3'b011, 16'h0010, "R2 ea inc-one");
    doRead(2'd0, 3'd1, 16'h0011, "R4 inc-one");
    doAccess(1, 3'b001, 16'h0011, "R2 ea inc-step");
    doRead(2'd0, 3'd1, 16'h0015, "R5 inc-step");
    doAccess(1, 3'b000, 16'h0015, "R2 ea dec-step");
    doRead(2'd0, 3'd1, 16'h0011, "R5 dec-step");
    doAccess(1, 3'b010, 16'h0011, "R2 ea dec-one");
    doRead(2'd0, 3'd1, 16'h0010, "R4 dec-one");
    doAccess(1, 3'b100, 16'h0010, "R2 ea hold");
    doRead(2'd0, 3'd1, 16'h0010, "R6 hold code");
    doAccess(1, 3'b110, 16'h0010, "R2 ea spare");
    doRead(2'd0, 3'd1, 16'h0010, "R6 spare code");
    doAccess(1, 3'b101, 16'h0014, "R3 indexed ea");
    doRead(2'd0, 3'd1, 16'h0010, "R3 pointer kept");
    doAccess(1, 3'b111, 16'h000F, "R7 predec ea");
    doRead(2'd0, 3'd1, 16'h000F, "R7 predec stored");
    doRead(2'd0, 3'd0, 16'h0000, "R11 set 0 untouched");

    // R8 linear wrap on set 0
    doAccess(0, 3'b010, 16'h0000, "R8 ea at zero");
    doRead(2'd0, 3'd0, 16'hFFFF, "R8 wrap below zero");
    doAccess(0, 3'b011, 16'hFFFF, "R8 ea at top");
    doRead(2'd0, 3'd0, 16'h0000, "R8 wrap above top");

    // R9 circular buffer of 10 words on set 2
    doWrite(2'd2, 3'd2, 16'h0009);
    doWrite(2'd0, 3'd2, 16'h0029);
    doWrite(2'd1, 3'd2, 16'h0003);
    doAccess(2, 3'b011, 16'h0029, "R9 ea top");
    doRead(2'd0, 3'd2, 16'h0020, "R9 inc past top");
    doAccess(2, 3'b010, 16'h0020, "R9 ea base");
    doRead(2'd0, 3'd2, 16'h0029, "R9 dec past base");
    doAccess(2, 3'b001, 16'h0029, "R9 ea step up");
    doRead(2'd0, 3'd2, 16'h0022, "R9 inc-step wrap");
    doAccess(2, 3'b000, 16'h0022, "R9 ea step down");
    doRead(2'd0, 3'd2, 16'h0029, "R9 dec-step wrap");
    doWrite(2'd0, 3'd2, 16'h0028);
    doAccess(2, 3'b101, 16'h0021, "R9 indexed wrap");
    doRead(2'd0, 3'd2, 16'h0028, "R9 indexed keeps pointer");
    doRead(2'd0, 3'd1, 16'h000F, "R11 set 1 untouched");

    // R10 bit-reversed on set 3
    doWrite(2'd2, 3'd3, 16'h0000);
    doWrite(2'd1, 3'd3, 16'h8000);
    doAccess(3, 3'b001, 16'h0000, "R10 ea first");
    doRead(2'd0, 3'd3, 16'h8000, "R10 step one");
    doAccess(3, 3'b001, 16'h8000, "R10 ea second");
    doRead(2'd0, 3'd3, 16'h4000, "R10 step two");
    doAccess(3, 3'b001, 16'h4000, "R10 ea third");
    doRead(2'd0, 3'd3, 16'hC000, "R10 step three");
    doAccess(3, 3'b000, 16'hC000, "R10 ea back");
    doRead(2'd0, 3'd3, 16'h4000, "R10 reversed decrement");

    // R12 write priority on set 4
    doWrite(2'd0, 3'd4, 16'h0100);
    doAccessWrite(4, 3'b011, 16'h0100, 2'd0, 3'd4, 16'h0200, "R12 ea during write");
    doRead(2'd0, 3'd4, 16'h0200, "R12 pointer write wins");
    doAccessWrite(4, 3'b011, 16'h0200, 2'd1, 3'd4, 16'h0007, "R12 ea step write");
    doRead(2'd0, 3'd4, 16'h0201, "R12 update not blocked");
    doRead(2'd1, 3'd4, 16'h0007, "R12 step written");

    // R13 no strike, no change
    doIdle(4, 3'b011);
    doIdle(4, 3'b111);
    doRead(2'd0, 3'd4, 16'h0201, "R13 pointer kept without strike");

    @(posedge clk); #1;
    quiet();
    @(posedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule